// File: doc/BRIEF.md
# Integer Shift and Rotate Execution Unit

This block executes the shift group of a 32-bit integer core's register-format instructions. The decode stage hands it the 6-bit function code, the 5-bit shift-amount field, two selector bits taken from the instruction word, and the two source operand values. It returns the shifted value, a register write enable and a flag that says the function code names a real shift. The supported operations are left logical, right logical, right arithmetic and right rotate. Each comes in two forms: one takes its amount from the instruction's immediate field, the other from the low five bits of the first source operand.

The two rotate operations have no function code of their own. Each shares its code with a logical right shift, and a spare instruction bit chooses between them. The immediate form uses instruction bit 21 as that selector, which is the lowest bit of the first-source register field. The register form uses instruction bit 6, which is the lowest bit of the shift-amount field. The all-zero instruction word and the related no-op and barrier words all fall into the immediate left-shift code. They need no special handling, because a left shift by zero of register zero writes nothing harmful.

All outputs are registered once. A result appears on the clock edge after its inputs were presented.

Top module: `shift_unit`

## Requirements
- R1: Function code 0x00 returns the second operand shifted left by the immediate amount, with zeros shifted in.
- R2: Function code 0x02 with instruction bit 21 low returns the second operand shifted right by the immediate amount, with zeros shifted in.
- R3: Function code 0x02 with instruction bit 21 high rotates the second operand right by the immediate amount. Bits leaving position 0 re-enter at position 31, so the count of one bits is preserved.
- R4: Function code 0x03 shifts the second operand right by the immediate amount and copies bit 31 into every vacated position.
- R5: Function codes 0x04, 0x06 (with instruction bit 6 low) and 0x07 perform the left logical, right logical and right arithmetic shifts. Their amount is bits 4:0 of the first operand, and bits 31:5 of that operand have no effect.
- R6: Function code 0x06 with instruction bit 6 high rotates the second operand right by bits 4:0 of the first operand.
- R7: A rotate by an amount of zero, in either form, returns the second operand unchanged.
- R8: For function code 0x00 the first operand and both selector bits have no effect. With an amount of zero, as in the all-zero no-op word, the result equals the second operand.
- R9: Function codes 0x01, 0x05 and every code from 0x08 to 0x3F drive the valid flag and the write enable low and the result to zero.
- R10: The six valid codes (0x00, 0x02, 0x03, 0x04, 0x06, 0x07) drive both the valid flag and the write enable high.
- R11: Outputs change on the rising clock edge after the inputs. While reset is low all three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_code | input | 6 | Function code field of the instruction |
| sa_fld | input | 5 | Immediate shift-amount field |
| sel_b21 | input | 1 | Instruction bit 21, rotate selector for the immediate form |
| sel_b6 | input | 1 | Instruction bit 6, rotate selector for the register form |
| rs_val | input | 32 | First source operand; bits 4:0 give the register-form amount |
| rt_val | input | 32 | Second source operand, the value that is shifted |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Registered destination write enable |
| op_valid | output | 1 | Registered flag: the function code is a supported shift |

## Verification
Each of the six operations is driven with every amount from 0 to 31. The operands are random, along with a pattern that has only the top bit set and one of all ones. The top-bit pattern separates arithmetic fill from zero fill. The all-ones pattern shows whether a rotate loses or duplicates bits at the wrap point. For the register forms, the first operand carries random upper bits and a conflicting immediate field, so an amount taken from the wrong place shows up. A sweep over all 64 function codes, with the selectors toggled, separates valid codes from invalid ones, and no-op words confirm the identity result.

// File: rtl/shu_pkg.sv
package shu_pkg;

    // Datapath width and the amount width derived from it
    localparam int XLEN = 32;
    localparam int AW   = $clog2(XLEN);

    // Function codes inside the register-format shift group
    localparam logic [5:0] FN_LSL_IMM = 6'h00;
    localparam logic [5:0] FN_LSR_IMM = 6'h02;
    localparam logic [5:0] FN_ASR_IMM = 6'h03;
    localparam logic [5:0] FN_LSL_REG = 6'h04;
    localparam logic [5:0] FN_LSR_REG = 6'h06;
    localparam logic [5:0] FN_ASR_REG = 6'h07;

    // Kind of movement the barrel network performs
    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shkind_e;

endpackage

// File: rtl/shu_decode.sv
module shu_decode
    import shu_pkg::*;
#(
    parameter int AMT_W = shu_pkg::AW
) (
    input  logic [5:0]       fn_code,
    input  logic [AMT_W-1:0] sa_fld,
    input  logic [AMT_W-1:0] rs_amt,
    input  logic             sel_b21,
    input  logic             sel_b6,
    output shkind_e          kind,
    output logic [AMT_W-1:0] amt,
    output logic             vld
);

    always_comb begin
        kind = SK_LSL;
        amt  = '0;
        vld  = 1'b0;
        unique case (fn_code)
            FN_LSL_IMM: begin
                kind = SK_LSL;
                amt  = sa_fld;
                vld  = 1'b1;
            end
            FN_LSR_IMM: begin
                // bit 21 picks rotate for the immediate form
                kind = sel_b21 ? SK_ROR : SK_LSR;
                amt  = sa_fld;
                vld  = 1'b1;
            end
            FN_ASR_IMM: begin
                kind = SK_ASR;
                amt  = sa_fld;
                vld  = 1'b1;
            end
            FN_LSL_REG: begin
                kind = SK_LSL;
                amt  = rs_amt;
                vld  = 1'b1;
            end
            FN_LSR_REG: begin
                // bit 6 picks rotate for the register form
                kind = sel_b6 ? SK_ROR : SK_LSR;
                amt  = rs_amt;
                vld  = 1'b1;
            end
            FN_ASR_REG: begin
                kind = SK_ASR;
                amt  = rs_amt;
                vld  = 1'b1;
            end
            default: begin
                kind = SK_LSL;
                amt  = '0;
                vld  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/shu_barrel.sv
module shu_barrel
    import shu_pkg::*;
#(
    parameter int DW    = shu_pkg::XLEN,
    parameter int AMT_W = $clog2(DW)
) (
    input  logic [DW-1:0]    din,
    input  logic [AMT_W-1:0] amt,
    input  shkind_e          kind,
    output logic [DW-1:0]    dout
);

    // A left shift runs through the right-moving network on bit-reversed data
    logic              is_left;
    logic              is_rot;
    logic              fill;
    logic [DW-1:0]     din_rev;
    logic [DW-1:0]     net_out_rev;
    logic [AMT_W:0][DW-1:0] stg;

    assign is_left = (kind == SK_LSL);
    assign is_rot  = (kind == SK_ROR);
    assign fill    = (kind == SK_ASR) ? din[DW-1] : 1'b0;

    for (genvar i = 0; i < DW; i++) begin : g_rev_in
        assign din_rev[i] = din[DW-1-i];
    end

    assign stg[0] = is_left ? din_rev : din;

    // One stage per amount bit; each stage moves by a power of two
    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [DW-1:0] moved;
        assign moved = is_rot ? {stg[k][D-1:0], stg[k][DW-1:D]}
                              : {{D{fill}}, stg[k][DW-1:D]};
        assign stg[k+1] = amt[k] ? moved : stg[k];
    end

    for (genvar i = 0; i < DW; i++) begin : g_rev_out
        assign net_out_rev[i] = stg[AMT_W][DW-1-i];
    end

    assign dout = is_left ? net_out_rev : stg[AMT_W];

endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shu_pkg::*;
#(
    parameter int XW = shu_pkg::XLEN,
    localparam int SW = $clog2(XW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [5:0]    fn_code,
    input  logic [SW-1:0] sa_fld,
    input  logic          sel_b21,
    input  logic          sel_b6,
    input  logic [XW-1:0] rs_val,
    input  logic [XW-1:0] rt_val,
    output logic [XW-1:0] result,
    output logic          wr_en,
    output logic          op_valid
);

    typedef struct packed {
        logic [XW-1:0] res;
        logic          wen;
        logic          vld;
    } shu_state_t;

    shkind_e       dec_kind;
    logic [SW-1:0] dec_amt;
    logic          dec_vld;
    logic [XW-1:0] net_res;
    shu_state_t    st_d, st_q;

    shu_decode #(.AMT_W(SW)) u_dec (
        .fn_code (fn_code),
        .sa_fld  (sa_fld),
        .rs_amt  (rs_val[SW-1:0]),
        .sel_b21 (sel_b21),
        .sel_b6  (sel_b6),
        .kind    (dec_kind),
        .amt     (dec_amt),
        .vld     (dec_vld)
    );

    shu_barrel #(.DW(XW), .AMT_W(SW)) u_net (
        .din  (rt_val),
        .amt  (dec_amt),
        .kind (dec_kind),
        .dout (net_res)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = dec_vld;
        st_d.wen = dec_vld;
        st_d.res = dec_vld ? net_res : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result   = st_q.res;
    assign wr_en    = st_q.wen;
    assign op_valid = st_q.vld;

    // R9: an unsupported code leaves nothing behind
    a_r9_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (result == '0) && !wr_en);

    // R10: every supported code is flagged on the next edge
    a_r10_valid_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code == 6'h00 || fn_code == 6'h02 || fn_code == 6'h03 ||
         fn_code == 6'h04 || fn_code == 6'h06 || fn_code == 6'h07)
        |=> op_valid && wr_en);

    // R3: an immediate rotate keeps the number of set bits
    a_r3_rot_popcount: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code == 6'h02 && sel_b21)
        |=> $countones(result) == $countones($past(rt_val)));

    // R7: a register-form rotate by zero is the identity
    a_r7_rot_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code == 6'h06 && sel_b6 && rs_val[SW-1:0] == '0)
        |=> result == $past(rt_val));

    // R8: the no-op word form passes the operand through
    a_r8_nop_ident: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_code == 6'h00 && sa_fld == '0) |=> result == $past(rt_val));

endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  fn_code;
    logic [4:0]  sa_fld;
    logic        sel_b21;
    logic        sel_b6;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [31:0] result;
    logic        wr_en;
    logic        op_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    shift_unit u_shift_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .fn_code  (fn_code),
        .sa_fld   (sa_fld),
        .sel_b21  (sel_b21),
        .sel_b6   (sel_b6),
        .rs_val   (rs_val),
        .rt_val   (rt_val),
        .result   (result),
        .wr_en    (wr_en),
        .op_valid (op_valid)
    );

    // Reference: op 0 lsl, 1 lsr, 2 asr, 3 ror
    function automatic logic [31:0] ref_calc(int op, logic [31:0] v, int a);
        logic [63:0] dbl;
        case (op)
            0: return v << a;
            1: return v >> a;
            2: return 32'($signed(v) >>> a);
            default: begin
                dbl = {v, v} >> a;
                return dbl[31:0];
            end
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] exp_res, logic exp_v);
        n_chk++;
        if (result !== exp_res || op_valid !== exp_v || wr_en !== exp_v) begin
            n_fail++;
            $display("FAIL %s: res=%h vld=%b wen=%b expected res=%h vld=%b wen=%b",
                     tag, result, op_valid, wr_en, exp_res, exp_v, exp_v);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge
    task automatic apply(logic [5:0] f, logic [4:0] s, logic b21, logic b6,
                         logic [31:0] rs, logic [31:0] rt);
        @(negedge clk);
        fn_code = f; sa_fld = s; sel_b21 = b21; sel_b6 = b6;
        rs_val = rs; rt_val = rt;
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] pats [4];
        rst_n = 1'b0;
        fn_code = 6'h02; sa_fld = 5'd3; sel_b21 = 1'b1; sel_b6 = 1'b1;
        rs_val = 32'hFFFF_FFFF; rt_val = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        check("R11 reset state", 32'h0, 1'b0);
        rst_n = 1'b1;

        // R11: one-edge latency
        @(negedge clk);
        fn_code = 6'h00; sa_fld = 5'd4; rt_val = 32'h0000_0011;
        @(posedge clk); #1;
        check("R11 latency", 32'h0000_0110, 1'b1);
        @(negedge clk);

        pats[0] = 32'h8000_0000;
        pats[1] = 32'hFFFF_FFFF;
        for (int p = 2; p < 4; p++) pats[p] = $urandom;

        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 32; a++) begin
                logic [31:0] v;
                logic [31:0] rsx;
                logic [4:0]  junk;
                v    = pats[p];
                junk = 5'(a + 7);
                rsx  = {$urandom} & 32'hFFFF_FFE0 | 32'(a);
                apply(6'h00, 5'(a), 1'b0, 1'b0, 32'h0, v);
                check("R1 lsl imm", ref_calc(0, v, a), 1'b1);
                apply(6'h02, 5'(a), 1'b0, a[0], 32'h0, v);
                check("R2 lsr imm", ref_calc(1, v, a), 1'b1);
                apply(6'h02, 5'(a), 1'b1, a[0], 32'h0, v);
                check(a == 0 ? "R7 ror imm zero" : "R3 ror imm", ref_calc(3, v, a), 1'b1);
                apply(6'h03, 5'(a), 1'b0, a[0], 32'h0, v);
                check("R4 asr imm", ref_calc(2, v, a), 1'b1);
                apply(6'h04, junk, 1'b1, junk[0], rsx, v);
                check("R5 lsl reg", ref_calc(0, v, a), 1'b1);
                apply(6'h06, {junk[4:1], 1'b0}, 1'b1, 1'b0, rsx, v);
                check("R5 lsr reg", ref_calc(1, v, a), 1'b1);
                apply(6'h07, junk, 1'b1, junk[0], rsx, v);
                check("R5 asr reg", ref_calc(2, v, a), 1'b1);
                apply(6'h06, {junk[4:1], 1'b1}, 1'b0, 1'b1, rsx, v);
                check(a == 0 ? "R7 ror reg zero" : "R6 ror reg", ref_calc(3, v, a), 1'b1);
            end
        end

        // R8: no-op words and ignored fields on code 0x00
        apply(6'h00, 5'd0, 1'b0, 1'b0, 32'h0, 32'h1234_5678);
        check("R8 nop word", 32'h1234_5678, 1'b1);
        apply(6'h00, 5'd0, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'hCAFE_F00D);
        check("R8 selectors ignored", 32'hCAFE_F00D, 1'b1);
        apply(6'h00, 5'd8, 1'b1, 1'b0, 32'h0000_001F, 32'h00AB_CDEF);
        check("R8 rs ignored", 32'hABCD_EF00, 1'b1);

        // R9 / R10: sweep every function code
        for (int f = 0; f < 64; f++) begin
            logic good;
            good = (f == 0 || f == 2 || f == 3 || f == 4 || f == 6 || f == 7);
            apply(6'(f), 5'd1, f[0], f[1], 32'h1, 32'h0000_0002);
            if (good) begin
                logic [31:0] e;
                case (f)
                    0, 4:    e = 32'h4;
                    default: e = 32'h1;
                endcase
                check("R10 valid code", e, 1'b1);
            end else begin
                check("R9 invalid code", 32'h0, 1'b0);
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule